// File: doc/BRIEF.md
# Stack Sequencer for Push, Pop, Call and Return

This block owns the 8-bit stack pointer of a small controller core and turns each stack request into a short sequence of accesses on a single-port internal RAM of 256 bytes. It handles five requests: store one byte, remove one byte, save a 16-bit return address for a subroutine call, restore it on return, and the same restore on return from an interrupt. The interrupt return also emits a strobe that lets the interrupt logic accept new interrupts. The status word is not restored.

The stack grows upward. A store first advances the pointer and then writes at the new location. A removal reads at the current location and then moves the pointer back. A call saves the low byte of the return address first and then the high byte. A return reads them back in the opposite order. The return address comes from the instruction sequencer, which has already added the length of the call instruction (2 or 3 bytes). One corner case needs its own handling: the removed byte can target the pointer itself. In that case the pointer is first moved back and then overwritten by the byte that was read.

The RAM has a registered read port, so read data appears one clock after the address. A request is a non-zero operation code held for one clock while the block is idle. `done` is a one-clock pulse after the last access. Results and the pointer are registered outputs.

Top module: `stack_seq_unit`

## Requirements
- R1: Reset is synchronous and active high. It sets the pointer to 0x07 and holds `done`, `irq_clear` and `ram_we` low.
- R2: A push (op code 1) raises the pointer by one and writes `push_data` at the new pointer value. `done` pulses one clock after the write cycle, which makes the latency 1 clock after acceptance.
- R3: A pop (op code 2) with `pop_to_sp` low reads the byte at the current pointer and presents it on `pop_data`. It then lowers the pointer by one. `done` comes 2 clocks after acceptance.
- R4: A pop with `pop_to_sp` high lowers the pointer and then loads it with the byte read. From pointer 0x4F with 0x30 stored there, the final pointer is 0x30.
- R5: A call (op code 3) writes `call_pc[7:0]` at pointer+1 and then `call_pc[15:8]` at pointer+2, in that order. The final pointer is pointer+2, and `done` comes 2 clocks after acceptance.
- R6: A return (op code 4) reads the high byte at the pointer and the low byte at pointer-1. It presents them as `ret_pc` and leaves the pointer lowered by 2, with `done` 3 clocks after acceptance and `irq_clear` low.
- R7: A return from interrupt (op code 5) behaves as R6 and also raises `irq_clear` for exactly the cycle in which `done` is high.
- R8: All pointer and address arithmetic wraps modulo 256. For example, a call at pointer 0xFE writes addresses 0xFF and then 0x00.
- R9: A request made while a sequence is in progress is ignored, and so are op codes 6 and 7. An ignored request causes no RAM write, no pointer change and no `done`.
- R10: `done` is high for a single clock per accepted request and never for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 3 | Operation request: 0 none, 1 push, 2 pop, 3 call, 4 return, 5 interrupt return |
| push_data | input | 8 | Byte to store on push |
| call_pc | input | 16 | Return address to save on call |
| pop_to_sp | input | 1 | Pop result goes to the stack pointer |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data, valid one clock after the address |
| pop_data | output | 8 | Byte read by the last pop |
| ret_pc | output | 16 | Address restored by the last return |
| sp | output | 8 | Current stack pointer |
| irq_clear | output | 1 | Interrupt-in-progress clear strobe |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with its default 8-bit width and a reset pointer of 0x07, so the whole 256-byte stack space is reachable. The pointer-load pop moves the pointer to any address in one request, which places a call across the 0xFF to 0x00 boundary without hundreds of pushes. It also sets up pointer values away from the reset value for the call, return and interrupt-return cases. Because the width is small, the bench's RAM model covers the full address space, and every write can be checked against the expected address and byte.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_RETI = 3'd5
  } stk_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WFIN,
    S_CALL_HI,
    S_POP_RD,
    S_POP_FIN,
    S_RET_HI,
    S_RET_LO,
    S_RET_FIN
  } stk_state_e;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned W      = 8,
  parameter int unsigned SP_RST = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] sp
);

  localparam logic [W-1:0] ONE = W'(1);

  // load wins over step so a self-targeted pop ends on the popped value
  always_ff @(posedge clk) begin
    if (rst)      sp <= W'(SP_RST);
    else if (ld)  sp <= ld_val;
    else if (inc) sp <= sp + ONE;
    else if (dec) sp <= sp - ONE;
  end

endmodule

// File: rtl/stk_capture.sv
module stk_capture #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cap_byte,
  input  logic           cap_hi,
  input  logic           cap_lo,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   pop_data,
  output logic [2*W-1:0] ret_pc
);

  logic [W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      if (cap_byte) pop_data <= din;
      if (cap_hi)   hi_q     <= din;
      if (cap_lo)   lo_q     <= din;
    end
  end

  assign ret_pc = {hi_q, lo_q};

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     req_op,
  input  logic [W-1:0]   push_data,
  input  logic [2*W-1:0] call_pc,
  input  logic           pop_to_sp,
  input  logic [W-1:0]   sp,
  output logic [W-1:0]   ram_addr,
  output logic [W-1:0]   ram_wdata,
  output logic           ram_we,
  output logic           sp_inc,
  output logic           sp_dec,
  output logic           sp_ld,
  output logic           cap_byte,
  output logic           cap_hi,
  output logic           cap_lo,
  output logic           done,
  output logic           irq_clear,
  output logic           busy
);

  localparam logic [W-1:0] ONE = W'(1);

  stk_state_e   st;
  logic [W-1:0] pc_hi_q;
  logic         tosp_q;
  logic         reti_q;
  logic         idle_push, idle_call;

  assign busy      = (st != S_IDLE);
  assign idle_push = (st == S_IDLE) && (req_op == OP_PUSH);
  assign idle_call = (st == S_IDLE) && (req_op == OP_CALL);

  always_comb begin
    sp_inc   = idle_push || idle_call || (st == S_CALL_HI);
    sp_dec   = (st == S_POP_RD) || (st == S_RET_HI) || (st == S_RET_LO);
    sp_ld    = (st == S_POP_FIN) && tosp_q;
    cap_byte = (st == S_POP_FIN);
    cap_hi   = (st == S_RET_LO);
    cap_lo   = (st == S_RET_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ram_addr  <= '0;
      ram_wdata <= '0;
      ram_we    <= 1'b0;
      pc_hi_q   <= '0;
      tosp_q    <= 1'b0;
      reti_q    <= 1'b0;
      done      <= 1'b0;
      irq_clear <= 1'b0;
    end else begin
      done      <= 1'b0;
      irq_clear <= 1'b0;
      ram_we    <= 1'b0;
      unique case (st)
        S_IDLE: begin
          case (req_op)
            OP_PUSH: begin
              ram_addr  <= sp + ONE;
              ram_wdata <= push_data;
              ram_we    <= 1'b1;
              st        <= S_WFIN;
            end
            OP_CALL: begin
              ram_addr  <= sp + ONE;
              ram_wdata <= call_pc[W-1:0];
              ram_we    <= 1'b1;
              pc_hi_q   <= call_pc[2*W-1:W];
              st        <= S_CALL_HI;
            end
            OP_POP: begin
              ram_addr <= sp;
              tosp_q   <= pop_to_sp;
              st       <= S_POP_RD;
            end
            OP_RET, OP_RETI: begin
              ram_addr <= sp;
              reti_q   <= (req_op == OP_RETI);
              st       <= S_RET_HI;
            end
            default: st <= S_IDLE;
          endcase
        end
        S_CALL_HI: begin
          ram_addr  <= sp + ONE;
          ram_wdata <= pc_hi_q;
          ram_we    <= 1'b1;
          st        <= S_WFIN;
        end
        S_WFIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_POP_RD:  st <= S_POP_FIN;
        S_POP_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_RET_HI: begin
          ram_addr <= sp - ONE;
          st       <= S_RET_LO;
        end
        S_RET_LO: st <= S_RET_FIN;
        S_RET_FIN: begin
          done      <= 1'b1;
          irq_clear <= reti_q;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stack_seq_unit.sv
module stack_seq_unit #(
  parameter int unsigned W      = 8,
  parameter int unsigned SP_RST = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     req_op,
  input  logic [W-1:0]   push_data,
  input  logic [2*W-1:0] call_pc,
  input  logic           pop_to_sp,
  output logic [W-1:0]   ram_addr,
  output logic [W-1:0]   ram_wdata,
  output logic           ram_we,
  input  logic [W-1:0]   ram_rdata,
  output logic [W-1:0]   pop_data,
  output logic [2*W-1:0] ret_pc,
  output logic [W-1:0]   sp,
  output logic           irq_clear,
  output logic           done
);

  logic sp_inc, sp_dec, sp_ld;
  logic cap_byte, cap_hi, cap_lo;
  logic busy_w;

  stk_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_op    (req_op),
    .push_data (push_data),
    .call_pc   (call_pc),
    .pop_to_sp (pop_to_sp),
    .sp        (sp),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we),
    .sp_inc    (sp_inc),
    .sp_dec    (sp_dec),
    .sp_ld     (sp_ld),
    .cap_byte  (cap_byte),
    .cap_hi    (cap_hi),
    .cap_lo    (cap_lo),
    .done      (done),
    .irq_clear (irq_clear),
    .busy      (busy_w)
  );

  stk_ptr #(.W(W), .SP_RST(SP_RST)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .inc    (sp_inc),
    .dec    (sp_dec),
    .ld     (sp_ld),
    .ld_val (ram_rdata),
    .sp     (sp)
  );

  stk_capture #(.W(W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_byte (cap_byte),
    .cap_hi   (cap_hi),
    .cap_lo   (cap_lo),
    .din      (ram_rdata),
    .pop_data (pop_data),
    .ret_pc   (ret_pc)
  );

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int unsigned W      = 8,
  parameter int unsigned SP_RST = 7
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   req_op,
  input logic         busy,
  input logic         done,
  input logic         irq_clear,
  input logic         ram_we,
  input logic [W-1:0] sp
);

  localparam logic [W-1:0] ONE = W'(1);

  assert_reset_sp_R1: assert property (@(posedge clk)
    rst |=> (sp == W'(SP_RST)) && !done && !ram_we);

  assert_push_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_op == 3'd1) |=> (sp == $past(sp) + ONE) && ram_we);

  assert_pop_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_op == 3'd2) |=> $stable(sp) && !ram_we);

  assert_irq_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    irq_clear |-> done);

  assert_write_busy_R9: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind stack_seq_unit stack_seq_chk #(.W(W), .SP_RST(SP_RST)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_op    (req_op),
  .busy      (busy_w),
  .done      (done),
  .irq_clear (irq_clear),
  .ram_we    (ram_we),
  .sp        (sp)
);

// File: tb/stack_seq_unit_test.sv
module stack_seq_unit_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [2:0]   req_op;
  logic [7:0]   push_data;
  logic [15:0]  call_pc;
  logic         pop_to_sp;
  logic [7:0]   ram_addr, ram_wdata, ram_rdata;
  logic         ram_we;
  logic [7:0]   pop_data, sp;
  logic [15:0]  ret_pc;
  logic         irq_clear, done;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] ram [0:255];
  logic [7:0] wq_a[$];
  logic [7:0] wq_d[$];
  logic [7:0] ref_sp;

  always #2 clk = ~clk;

  stack_seq_unit uut (
    .clk(clk), .rst(rst), .req_op(req_op), .push_data(push_data),
    .call_pc(call_pc), .pop_to_sp(pop_to_sp), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .pop_data(pop_data), .ret_pc(ret_pc), .sp(sp),
    .irq_clear(irq_clear), .done(done)
  );

  always @(posedge clk) begin
    if (ram_we) ram[ram_addr] <= ram_wdata;
    ram_rdata <= ram[ram_addr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every RAM write is compared with the model's expected write order
  always @(negedge clk) begin
    if (!rst && ram_we) begin
      if (wq_a.size() == 0) begin
        chk("R9 unexpected RAM write", 32'(ram_addr), 32'hFFFF);
      end else begin
        logic [7:0] ea, ed;
        ea = wq_a.pop_front();
        ed = wq_d.pop_front();
        chk("R2 R5 R8 write address", 32'(ram_addr), 32'(ea));
        chk("R2 R5 write data", 32'(ram_wdata), 32'(ed));
      end
    end
  end

  task automatic do_op(input logic [2:0] op, input logic [7:0] d, input logic [15:0] pc,
                       input logic tosp, input bit inject, input string tag);
    logic [7:0]  e_sp, e_pop;
    logic [15:0] e_pc;
    int          lat;
    e_sp = ref_sp; e_pop = '0; e_pc = '0; lat = 0;
    case (op)
      3'd1: begin
        e_sp = 8'(ref_sp + 1);
        wq_a.push_back(e_sp); wq_d.push_back(d);
        lat = 1;
      end
      3'd2: begin
        e_pop = ram[ref_sp];
        e_sp  = tosp ? e_pop : 8'(ref_sp - 1);
        lat   = 2;
      end
      3'd3: begin
        wq_a.push_back(8'(ref_sp + 1)); wq_d.push_back(pc[7:0]);
        wq_a.push_back(8'(ref_sp + 2)); wq_d.push_back(pc[15:8]);
        e_sp = 8'(ref_sp + 2);
        lat  = 2;
      end
      default: begin
        e_pc = {ram[ref_sp], ram[8'(ref_sp - 1)]};
        e_sp = 8'(ref_sp - 2);
        lat  = 3;
      end
    endcase
    req_op = op; push_data = d; call_pc = pc; pop_to_sp = tosp;
    for (int n = 0; n <= lat; n++) begin
      @(negedge clk);
      if (n == 0) req_op = 3'd0;
      if (inject && n == 1) begin req_op = 3'd1; push_data = 8'hEE; end
      if (inject && n == 2) req_op = 3'd0;
      chk({tag, " R10 done timing"}, 32'(done), 32'(n == lat));
      if (n == lat) begin
        chk({tag, " final sp"}, 32'(sp), 32'(e_sp));
        if (op == 3'd2) chk({tag, " R3 pop_data"}, 32'(pop_data), 32'(e_pop));
        if (op >= 3'd4) begin
          chk({tag, " R6 ret_pc"}, 32'(ret_pc), 32'(e_pc));
          chk({tag, " R7 irq_clear"}, 32'(irq_clear), 32'(op == 3'd5));
        end
      end
    end
    @(negedge clk);
    chk({tag, " R10 done single"}, 32'(done), 32'h0);
    chk({tag, " R9 pending writes"}, 32'(wq_a.size()), 32'h0);
    ref_sp = e_sp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    rst = 1'b1; req_op = 3'd0; push_data = '0; call_pc = '0; pop_to_sp = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset sp", 32'(sp), 32'h07);
    chk("R1 reset done", 32'(done), 32'h0);
    chk("R1 reset we", 32'(ram_we), 32'h0);
    chk("R1 reset irq_clear", 32'(irq_clear), 32'h0);
    ref_sp = 8'h07;

    // R4: load the pointer with 0x4F from RAM[0x07]
    ram[8'h07] = 8'h4F;
    do_op(3'd2, 8'h00, 16'h0, 1'b1, 0, "R4 pop-to-sp");
    // R2: two pushes land at 0x50 and 0x51
    do_op(3'd1, 8'h11, 16'h0, 1'b0, 0, "R2 push 11");
    do_op(3'd1, 8'h12, 16'h0, 1'b0, 0, "R2 push 12");
    chk("R2 sp after pushes", 32'(sp), 32'h51);
    // R3: pops return in reverse order
    do_op(3'd2, 8'h00, 16'h0, 1'b0, 0, "R3 pop 12");
    do_op(3'd2, 8'h00, 16'h0, 1'b0, 0, "R3 pop 11");
    // R4: SP=0x4F holding 0x30 ends at 0x30
    ram[8'h4F] = 8'h30;
    do_op(3'd2, 8'h00, 16'h0, 1'b1, 0, "R4 pop-to-sp 30");
    chk("R4 sp loaded", 32'(sp), 32'h30);
    // R5 then R6
    do_op(3'd3, 8'h00, 16'h0232, 1'b0, 0, "R5 call");
    do_op(3'd4, 8'h00, 16'h0, 1'b0, 0, "R6 ret");
    chk("R6 ret address", 32'(ret_pc), 32'h0232);
    // R7 with a push injected while busy (R9)
    ram[8'h30] = 8'h0B;
    do_op(3'd2, 8'h00, 16'h0, 1'b1, 0, "R4 pop-to-sp 0B");
    ram[8'h0A] = 8'h30; ram[8'h0B] = 8'h02;
    do_op(3'd5, 8'h00, 16'h0, 1'b0, 1, "R7 reti R9 busy");
    chk("R7 reti address", 32'(ret_pc), 32'h0230);
    chk("R9 sp after ignored push", 32'(sp), 32'h09);
    // R9: undefined op codes
    req_op = 3'd6;
    @(negedge clk); req_op = 3'd7;
    @(negedge clk); req_op = 3'd0;
    repeat (3) @(negedge clk);
    chk("R9 undefined op sp", 32'(sp), 32'(ref_sp));
    chk("R9 undefined op done", 32'(done), 32'h0);
    // R8: wrap across 0xFF/0x00
    ram[8'h09] = 8'hFE;
    do_op(3'd2, 8'h00, 16'h0, 1'b1, 0, "R4 pop-to-sp FE");
    do_op(3'd3, 8'h00, 16'hBEEF, 1'b0, 0, "R8 call wrap");
    chk("R8 sp wrapped", 32'(sp), 32'h00);
    do_op(3'd4, 8'h00, 16'h0, 1'b0, 0, "R8 ret wrap");
    chk("R8 ret address wrapped", 32'(ret_pc), 32'hBEEF);
    do_op(3'd1, 8'h5A, 16'h0, 1'b0, 0, "R8 push FF");
    do_op(3'd1, 8'hA5, 16'h0, 1'b0, 0, "R8 push wrap 00");
    do_op(3'd2, 8'h00, 16'h0, 1'b0, 0, "R8 pop wrap 00");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule